// File: doc/BRIEF.md
# IDE Hidden Configuration Window

This block sits on the host I/O side of an IDE-compatible adapter channel and watches every host cycle aimed at the eight-byte task-file range that starts at a parameter base address (0x1F0 for a primary channel, 0x170 for a secondary one). Normally every access in that range is handed to the ordinary task file. A fixed host access pattern opens a hidden configuration window. While the window is open, the same eight offsets reach a small register set instead: read-cycle and write-cycle timing bytes, a control register, a read-only clock strap and a miscellaneous register.

There are two timing banks, A and B, each holding its own read-cycle and write-cycle byte. Bit 0 of the miscellaneous register, together with a control bit that unlocks bank B, chooses which bank the timing offsets address. A second control bit decides whether drive 1 takes its timing from bank B or shares bank A with drive 0. The block presents the resulting timing bytes for both drives and the shared miscellaneous byte as outputs. Something downstream turns them into bus waveforms.

Top module: `ide_cfgwin`

## Requirements
- R1: After reset, all four drive timing outputs equal the slowest timing value (parameter, default 0x5B), `shared_misc` is 0x00, the control register is 0x00, and the window is closed.
- R2: The window opens after two 16-bit reads at base+1 in a row, with the most recent two valid accesses being those reads, followed by a byte write of 0x03 to base+2. That write still passes to the task file. The window is open from the next access.
- R3: Any valid host access that does not continue the pattern returns the sequencer to the start. This includes an 8-bit read at base+1, a write, or an access at another address. Clock cycles with `io_valid` low leave the sequencer's progress unchanged.
- R4: While the window is open, a byte write of 0x83 to base+2 is claimed by the window and closes it. Later in-range accesses pass to the task file.
- R5: While the window is closed, every valid in-range access asserts `tf_pass` and not `cfg_claim`, and writes change no configuration register. While it is open, every valid in-range access asserts `cfg_claim` and not `tf_pass`. The two are never both high.
- R6: A claimed read returns the following on `io_rdata`:
  - offset 0: the read-cycle byte of the selected bank;
  - offset 1: the write-cycle byte of the selected bank;
  - offset 3: the control register;
  - offset 5: `{7'b0, strap}`, where strap is `strap_clk25` sampled at the previous clock edge (1 = 25 MHz, 0 = 33 MHz);
  - offset 6: the miscellaneous register;
  - offsets 2, 4 and 7: 0x00.

  `io_rdata` is 0x00 when no claimed read is present. Writes to offset 5 are ignored.
- R7: Bank B is selected when miscellaneous bit 0 and control bit 7 are both 1; otherwise bank A is selected. Claimed writes to offsets 0 and 1 update only the selected bank, and the new value shows on the outputs from the next cycle. Timing and misc outputs change only after a claimed write.
- R8: `drv0_*_tim` always come from bank A. `drv1_*_tim` come from bank B when control bit 0 is 1, and from bank A when it is 0. Writing 0xC0 to control unlocks bank B. Writing 0x85 unlocks it and splits the drives.
- R9: `shared_misc` always equals the miscellaneous register, which is written at offset 6 and is common to both drives.
- R10: Accesses outside base..base+7 assert neither `cfg_claim` nor `tf_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | One host I/O cycle present this clock |
| io_write | input | 1 | 1 = write, 0 = read |
| io_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Write data (low byte) |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| io_rdata | output | 8 | Read data for claimed reads |
| cfg_claim | output | 1 | Access served by the configuration window |
| tf_pass | output | 1 | Access forwarded to the normal task file |
| drv0_rd_tim | output | 8 | Drive 0 read-cycle timing |
| drv0_wr_tim | output | 8 | Drive 0 write-cycle timing |
| drv1_rd_tim | output | 8 | Drive 1 read-cycle timing |
| drv1_wr_tim | output | 8 | Drive 1 write-cycle timing |
| shared_misc | output | 8 | Shared address-setup, ready and prefetch settings |

## Verification
The bound checker watches every cycle for the following:
- claim and pass-through are exclusive and appear only for valid in-range accesses;
- the closing key always drops the claim on the next cycle;
- a strap read always returns the strap input from the cycle before;
- the timing and misc outputs hold still unless a claimed write happened.

Only the bench scenarios can show the history-dependent behaviour: that exactly the two-read-then-key pattern opens the window, that stray accesses break it while idle cycles do not, and that bank selection and drive mapping follow the control and misc bits.

// File: rtl/ide_cfgwin_pkg.sv
package ide_cfgwin_pkg;

  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;
  localparam int NBANK  = 2;

  // window register offsets
  localparam logic [OFF_W-1:0] OFF_RDTIM = 3'd0;
  localparam logic [OFF_W-1:0] OFF_WRTIM = 3'd1;
  localparam logic [OFF_W-1:0] OFF_KEY   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STRAP = 3'd5;
  localparam logic [OFF_W-1:0] OFF_MISC  = 3'd6;
  localparam logic [OFF_W-1:0] OFF_PROBE = 3'd1;

  localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h03;
  localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'h83;

  localparam int CTRL_BANKB_BIT = 7;
  localparam int CTRL_SPLIT_BIT = 0;
  localparam int MISC_IDX_BIT   = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_e;

  typedef struct packed {
    logic [BYTE_W-1:0] rd;
    logic [BYTE_W-1:0] wr;
  } tim_pair_t;

endpackage

// File: rtl/ide_cfgwin_rstsync.sv
module ide_cfgwin_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ide_cfgwin_seq.sv
module ide_cfgwin_seq
  import ide_cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_hit,
  input  logic              acc_write,
  input  logic              acc_wide,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic              win_open
);
  seq_e st_q, st_d;
  logic probe, key_open, key_close;

  assign probe     = acc_hit && !acc_write && acc_wide && (acc_off == OFF_PROBE);
  assign key_open  = acc_hit && acc_write && !acc_wide && (acc_off == OFF_KEY)
                     && (acc_wdata == KEY_OPEN);
  assign key_close = acc_hit && acc_write && !acc_wide && (acc_off == OFF_KEY)
                     && (acc_wdata == KEY_CLOSE);

  // next state: only valid host cycles move the sequencer
  always_comb begin
    st_d = st_q;
    if (acc_valid) begin
      unique case (st_q)
        SEQ_IDLE: st_d = probe ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:  st_d = probe ? SEQ_TWO : SEQ_IDLE;
        SEQ_TWO: begin
          if (probe)         st_d = SEQ_TWO;
          else if (key_open) st_d = SEQ_OPEN;
          else               st_d = SEQ_IDLE;
        end
        SEQ_OPEN: st_d = key_close ? SEQ_IDLE : SEQ_OPEN;
        default:  st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign win_open = (st_q == SEQ_OPEN);
endmodule

// File: rtl/ide_cfgwin_regs.sv
module ide_cfgwin_regs
  import ide_cfgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              strap_in,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] misc_q,
  output logic              strap_q
);
  logic              ctrl_en, misc_en;
  logic [BYTE_W-1:0] ctrl_d, misc_d;

  assign ctrl_en = wr_en && (wr_off == OFF_CTRL);
  assign misc_en = wr_en && (wr_off == OFF_MISC);

  always_comb begin
    ctrl_d = ctrl_q;
    misc_d = misc_q;
    if (ctrl_en) ctrl_d = wdata;
    if (misc_en) misc_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      misc_q  <= '0;
      strap_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      misc_q  <= misc_d;
      strap_q <= strap_in;
    end
  end
endmodule

// File: rtl/ide_cfgwin_tbank.sv
module ide_cfgwin_tbank
  import ide_cfgwin_pkg::*;
#(
  parameter int                NB        = NBANK,
  parameter int                SEL_W     = (NB > 1) ? $clog2(NB) : 1,
  parameter logic [BYTE_W-1:0] TIM_RESET = 8'h5B
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_rd,
  input  logic                  we_wr,
  input  logic [SEL_W-1:0]      wsel,
  input  logic [BYTE_W-1:0]     wdata,
  output tim_pair_t [NB-1:0]    bank_q
);
  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic      hit;
    tim_pair_t nxt;

    assign hit = (wsel == SEL_W'(g));

    always_comb begin
      nxt = bank_q[g];
      if (hit && we_rd) nxt.rd = wdata;
      if (hit && we_wr) nxt.wr = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g].rd <= TIM_RESET;
        bank_q[g].wr <= TIM_RESET;
      end else begin
        bank_q[g] <= nxt;
      end
    end
  end
endmodule

// File: rtl/ide_cfgwin.sv
module ide_cfgwin
  import ide_cfgwin_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01F0,
  parameter logic [7:0]        TIM_RESET = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic              io_wide,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              strap_clk25,
  output logic [7:0]        io_rdata,
  output logic              cfg_claim,
  output logic              tf_pass,
  output logic [7:0]        drv0_rd_tim,
  output logic [7:0]        drv0_wr_tim,
  output logic [7:0]        drv1_rd_tim,
  output logic [7:0]        drv1_wr_tim,
  output logic [7:0]        shared_misc
);
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic                  rst_sync_n;
  logic                  in_rng, hit, win_open, cfg_wr;
  logic [OFF_W-1:0]      off;
  logic [BYTE_W-1:0]     ctrl_q, misc_q;
  logic                  strap_q;
  logic [SEL_W-1:0]      bank_sel;
  tim_pair_t [NBANK-1:0] bank_q;
  tim_pair_t             sel_pair, drv1_pair;

  ide_cfgwin_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // address decode
  assign in_rng = (io_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);
  assign off    = io_addr[OFF_W-1:0];
  assign hit    = io_valid && in_rng;

  ide_cfgwin_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .acc_valid(io_valid), .acc_hit(hit), .acc_write(io_write),
    .acc_wide(io_wide), .acc_off(off), .acc_wdata(io_wdata),
    .win_open(win_open)
  );

  assign cfg_claim = hit && win_open;
  assign tf_pass   = hit && !win_open;
  assign cfg_wr    = cfg_claim && io_write;

  ide_cfgwin_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(cfg_wr), .wr_off(off), .wdata(io_wdata),
    .strap_in(strap_clk25),
    .ctrl_q(ctrl_q), .misc_q(misc_q), .strap_q(strap_q)
  );

  // bank B reachable only when unlocked by control and indexed by misc
  assign bank_sel = SEL_W'(misc_q[MISC_IDX_BIT] && ctrl_q[CTRL_BANKB_BIT]);

  ide_cfgwin_tbank #(
    .NB(NBANK), .SEL_W(SEL_W), .TIM_RESET(TIM_RESET)
  ) u_tbank (
    .clk(clk), .rst_n(rst_sync_n),
    .we_rd(cfg_wr && (off == OFF_RDTIM)),
    .we_wr(cfg_wr && (off == OFF_WRTIM)),
    .wsel(bank_sel), .wdata(io_wdata),
    .bank_q(bank_q)
  );

  assign sel_pair = bank_q[bank_sel];

  // host read path
  always_comb begin
    io_rdata = '0;
    if (cfg_claim && !io_write) begin
      unique case (off)
        OFF_RDTIM: io_rdata = sel_pair.rd;
        OFF_WRTIM: io_rdata = sel_pair.wr;
        OFF_CTRL:  io_rdata = ctrl_q;
        OFF_STRAP: io_rdata = {{(BYTE_W-1){1'b0}}, strap_q};
        OFF_MISC:  io_rdata = misc_q;
        default:   io_rdata = '0;
      endcase
    end
  end

  // drive-to-bank mapping
  assign drv1_pair   = ctrl_q[CTRL_SPLIT_BIT] ? bank_q[1] : bank_q[0];
  assign drv0_rd_tim = bank_q[0].rd;
  assign drv0_wr_tim = bank_q[0].wr;
  assign drv1_rd_tim = drv1_pair.rd;
  assign drv1_wr_tim = drv1_pair.wr;
  assign shared_misc = misc_q;
endmodule

// File: rtl/ide_cfgwin_chk.sv
module ide_cfgwin_chk #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h01F0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_valid,
  input logic              io_write,
  input logic              io_wide,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              strap_clk25,
  input logic [7:0]        io_rdata,
  input logic              cfg_claim,
  input logic              tf_pass,
  input logic [7:0]        drv0_rd_tim,
  input logic [7:0]        drv0_wr_tim,
  input logic [7:0]        drv1_rd_tim,
  input logic [7:0]        drv1_wr_tim,
  input logic [7:0]        shared_misc
);
  logic       in_rng;
  logic [2:0] off;
  logic [39:0] outs;

  assign in_rng = (io_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
  assign off    = io_addr[2:0];
  assign outs   = {drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, shared_misc};

  // R5
  claim_pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_claim && tf_pass));

  // R10
  range_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_claim || tf_pass) |-> (io_valid && in_rng));

  // R4
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_claim && io_write && !io_wide && off == 3'd2 && io_wdata == 8'h83)
    |=> !cfg_claim);

  // R6
  strap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_claim && !io_write && off == 3'd5) |-> (io_rdata == {7'b0, $past(strap_clk25)}));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_claim && io_write) |=> $stable(outs));
endmodule

bind ide_cfgwin ide_cfgwin_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
  .io_wide(io_wide), .io_addr(io_addr), .io_wdata(io_wdata),
  .strap_clk25(strap_clk25), .io_rdata(io_rdata), .cfg_claim(cfg_claim),
  .tf_pass(tf_pass), .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
  .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim), .shared_misc(shared_misc)
);

// File: tb/sim_ide_cfgwin.sv
`timescale 1ns/1ps
module sim_ide_cfgwin;
  localparam logic [15:0] B = 16'h01F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0, io_wide = 1'b0, strap_clk25 = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata, drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, shared_misc;
  logic        cfg_claim, tf_pass;

  always #2.5 clk = ~clk;

  ide_cfgwin u0 (.*);

  int nchk = 0, nfail = 0;
  bit strap_rand = 1'b0;

  // bench model
  int         m_st = 0;
  logic [7:0] m_ctrl = 0, m_misc = 0;
  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  logic       m_strap = 0;
  logic       g_claim, g_pass;
  logic [7:0] g_rdata;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] off, input logic bsel);
    case (off)
      3'd0: return m_rd[bsel];
      3'd1: return m_wr[bsel];
      3'd3: return m_ctrl;
      3'd5: return {7'b0, m_strap};
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic acc(input logic v, input logic w, input logic wd,
                     input logic [15:0] a, input logic [7:0] d);
    logic s, rng, opn, ec, ep, bsel, probe, kopen, kclose;
    logic [2:0] off;
    s = strap_rand ? 1'($urandom_range(0, 1)) : 1'b0;
    @(negedge clk);
    io_valid = v; io_write = w; io_wide = wd; io_addr = a; io_wdata = d; strap_clk25 = s;
    #1;
    rng  = (a[15:3] == B[15:3]);
    off  = a[2:0];
    opn  = (m_st == 3);
    ec   = v && rng && opn;
    ep   = v && rng && !opn;
    bsel = m_misc[0] && m_ctrl[7];
    g_claim = cfg_claim; g_pass = tf_pass; g_rdata = io_rdata;
    chk("R5", {7'b0, cfg_claim}, {7'b0, ec}, "claim");
    chk("R5", {7'b0, tf_pass}, {7'b0, ep}, "pass");
    chk("R6", io_rdata, (ec && !w) ? exp_read(off, bsel) : 8'h00, "rdata");
    chk("R8", drv0_rd_tim, m_rd[0], "drv0 rd");
    chk("R8", drv0_wr_tim, m_wr[0], "drv0 wr");
    chk("R8", drv1_rd_tim, m_ctrl[0] ? m_rd[1] : m_rd[0], "drv1 rd");
    chk("R8", drv1_wr_tim, m_ctrl[0] ? m_wr[1] : m_wr[0], "drv1 wr");
    chk("R9", shared_misc, m_misc, "misc");
    // model update
    if (ec && w) begin
      case (off)
        3'd0: m_rd[bsel] = d;
        3'd1: m_wr[bsel] = d;
        3'd3: m_ctrl = d;
        3'd6: m_misc = d;
        default: ;
      endcase
    end
    probe  = v && rng && !w && wd && off == 3'd1;
    kopen  = v && rng && w && !wd && off == 3'd2 && d == 8'h03;
    kclose = v && rng && w && !wd && off == 3'd2 && d == 8'h83;
    if (v) begin
      case (m_st)
        0: m_st = probe ? 1 : 0;
        1: m_st = probe ? 2 : 0;
        2: m_st = probe ? 2 : (kopen ? 3 : 0);
        default: m_st = kclose ? 0 : 3;
      endcase
    end
    m_strap = s;
  endtask

  task automatic idle(); acc(1'b0, 1'b0, 1'b0, 16'h0000, 8'h00); endtask
  task automatic wr8(input logic [2:0] o, input logic [7:0] d); acc(1'b1, 1'b1, 1'b0, B + 16'(o), d); endtask
  task automatic rd8(input logic [2:0] o); acc(1'b1, 1'b0, 1'b0, B + 16'(o), 8'h00); endtask
  task automatic probe16(); acc(1'b1, 1'b0, 1'b1, B + 16'd1, 8'h00); endtask
  task automatic unlock(); probe16(); probe16(); wr8(3'd2, 8'h03); endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    m_rd[0] = 8'h5B; m_rd[1] = 8'h5B; m_wr[0] = 8'h5B; m_wr[1] = 8'h5B;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) idle();

    // R1 reset state
    chk("R1", drv0_rd_tim, 8'h5B, "reset drv0 rd");
    chk("R1", drv1_wr_tim, 8'h5B, "reset drv1 wr");
    chk("R1", shared_misc, 8'h00, "reset misc");
    rd8(3'd3);
    chk("R1", {7'b0, g_pass}, 8'h01, "reset window closed");

    // R5 closed-window write does not reach control
    wr8(3'd3, 8'hC0);
    chk("R5", {7'b0, g_claim}, 8'h00, "closed write not claimed");

    // R2 unlock; key itself passes through
    probe16(); probe16(); wr8(3'd2, 8'h03);
    chk("R2", {7'b0, g_pass}, 8'h01, "key passes");
    rd8(3'd3);
    chk("R2", {7'b0, g_claim}, 8'h01, "open after key");
    chk("R5", g_rdata, 8'h00, "ctrl untouched by closed write");

    // R7 bank B locked: misc idx=1 but ctrl bit7=0 -> bank A
    wr8(3'd6, 8'h01);
    wr8(3'd0, 8'h11);
    idle();
    chk("R7", drv0_rd_tim, 8'h11, "locked B write lands in A");
    wr8(3'd3, 8'hC0);
    wr8(3'd0, 8'h22);
    wr8(3'd1, 8'h33);
    idle();
    chk("R7", drv0_rd_tim, 8'h11, "bank A kept");
    chk("R8", drv1_rd_tim, 8'h11, "unsplit drv1 uses A");
    rd8(3'd0);
    chk("R7", g_rdata, 8'h22, "read bank B");
    wr8(3'd3, 8'h85);
    idle();
    chk("R8", drv1_rd_tim, 8'h22, "split drv1 rd from B");
    chk("R8", drv1_wr_tim, 8'h33, "split drv1 wr from B");

    // R6 strap read-only and unmapped offsets
    strap_rand = 1'b1;
    wr8(3'd5, 8'hFF);
    rd8(3'd5);
    chk("R6", g_rdata & 8'hFE, 8'h00, "strap upper bits zero");
    rd8(3'd4);
    chk("R6", g_rdata, 8'h00, "unmapped offset");

    // R9 shared misc
    wr8(3'd6, 8'h5A);
    idle();
    chk("R9", shared_misc, 8'h5A, "misc out");

    // R10 out of range while open
    acc(1'b1, 1'b0, 1'b0, 16'h03F6, 8'h00);
    chk("R10", {6'b0, g_claim, g_pass}, 8'h00, "out of range");

    // R4 close
    wr8(3'd2, 8'h83);
    chk("R4", {7'b0, g_claim}, 8'h01, "close key claimed");
    rd8(3'd0);
    chk("R4", {7'b0, g_pass}, 8'h01, "closed after key");

    // R3 breaks
    probe16(); rd8(3'd1); probe16(); wr8(3'd2, 8'h03); rd8(3'd0);
    chk("R3", {7'b0, g_pass}, 8'h01, "byte read breaks");
    probe16(); acc(1'b1, 1'b0, 1'b1, 16'h03F6, 8'h00); probe16(); wr8(3'd2, 8'h03); rd8(3'd0);
    chk("R3", {7'b0, g_pass}, 8'h01, "foreign address breaks");
    probe16(); idle(); idle(); probe16(); idle(); wr8(3'd2, 8'h03); rd8(3'd0);
    chk("R3", {7'b0, g_claim}, 8'h01, "idle cycles keep progress");
    probe16(); probe16(); probe16(); wr8(3'd2, 8'h83);
    chk("R3", {7'b0, g_claim}, 8'h01, "probes while open stay open");

    // random phase
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        probe16();
        if ($urandom_range(0, 2) == 0) rd8(3'($urandom_range(0, 7)));
        probe16();
        wr8(3'd2, 8'h03);
      end
      for (int j = 0; j < 6; j++) begin
        logic [15:0] a;
        logic [7:0]  d;
        int          k;
        k = $urandom_range(0, 9);
        a = (k < 8) ? B + 16'(k) : ((k == 8) ? 16'h03F6 : B + 16'd8);
        case ($urandom_range(0, 5))
          0: d = 8'h03;
          1: d = 8'h83;
          2: d = 8'hC0;
          3: d = 8'h85;
          default: d = 8'($urandom);
        endcase
        acc(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0), a, d);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule